// File: doc/BRIEF.md
# Two-Wire Register Access Target with Auto-Increment

This block is a target on a two-wire serial bus (I2C-compatible, 7-bit addressing, no clock stretching). It lets a bus host reach a byte-wide register file of nineteen entries. The register file sits beside the block. The block drives a pointer that serves as the register address, a single-cycle write strobe with its data byte, a single-cycle fetch strobe for each byte it transmits, and a one-cycle reset pulse that makes the register file reload its defaults.

A host transaction opens with the device address. A write carries a pointer byte first and then any number of data bytes. The pointer moves forward after each data byte. A read shifts out the byte at the pointer, and each host acknowledge moves the pointer on. The pointer falls back to zero at every STOP, so a bare read polls entry zero. Entries 0x00 to 0x06 are read-only, and 0x07 to 0x12 are writable. A write to any other entry is acknowledged but produces no strobe. The register file can be reset in two ways: a general-call command, or a reserved pointer value.

The bus lines pass through two-flop synchronizers and are sampled by the system clock. The block pulls SDA low through an open-drain enable.

Top module: `i2c_regmap_target`

## Requirements
- R1: The block acknowledges address byte 0x90 (write) and 0x91 (read), which is 7-bit address 0x48. It does not acknowledge any other non-zero address byte and then ignores the bus until the next START. Bytes are MSB first, and the acknowledge is a low SDA during the ninth SCL pulse.
- R2: In a write, the first byte after the address loads the pointer. Each later byte produces one write strobe at the current pointer, and the pointer then increments by one.
- R3: A repeated START is handled like a START and keeps the pointer, so a pointer write followed by a repeated START and a read returns that entry.
- R4: A STOP returns the block to idle and clears the pointer to 0x00.
- R5: In a read, the byte at the pointer is sent MSB first. A host acknowledge advances the pointer and starts the next byte. A host not-acknowledge releases SDA, returns the block to idle and leaves the pointer unchanged.
- R6: A data byte sent to a read-only entry (0x00 to 0x06) or to an entry above 0x12 is acknowledged, but it raises no write strobe and changes no register.
- R7: The general-call address byte 0x00 is acknowledged. A following byte of 0x06 is acknowledged and raises the register-reset pulse. Any other byte in that position is not acknowledged and raises no pulse.
- R8: A pointer byte of 0xBF is acknowledged, raises the register-reset pulse and sets the pointer to 0x00.
- R9: After reset, SDA is released, all strobes are low and the pointer is 0x00.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 8 | Pointer, used as register address |
| reg_rdata | input | 8 | Register file read data at reg_addr |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle strobe when a byte is fetched for transmit |
| regs_reset | output | 1 | One-cycle pulse: reload register defaults |

## Verification
A corrupted pointer shows at the ports within one byte. The next write strobe lands at the wrong reg_addr, or the next byte read returns a neighbouring entry. A broken STOP clear appears on the first bare read, which then returns something other than entry zero. A wrong receive count or a wrong acknowledge decision moves or drops the ninth-clock low on SDA, so the host sees a missing or extra acknowledge in that same byte. Strobes that fire at the wrong time are caught by counting write and reset pulses across each transaction.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;

    localparam int PTR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_RD_LOAD,
        ST_RD_BIT,
        ST_RD_ACK
    } eng_state_t;

    // meaning of the byte being received
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_GC
    } rx_phase_t;

    // where to go once the acknowledge slot ends
    typedef enum logic [1:0] {
        NX_RX,
        NX_READ,
        NX_IDLE
    } after_ack_t;

    typedef struct packed {
        eng_state_t           state;
        rx_phase_t            phase;
        after_ack_t           after;
        logic [3:0]           cnt;
        logic [7:0]           shift;
        logic [PTR_W-1:0]     ptr;
        logic                 sda_oe;
        logic                 we;
        logic                 inc;
        logic [7:0]           wdata;
        logic                 re;
        logic                 rst;
        logic                 mack;
    } eng_regs_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

endpackage

// File: rtl/i2c_rm_sync.sv
module i2c_rm_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    // one independent flop chain per line; idle bus level is high
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_rm_cond.sv
module i2c_rm_cond
    import i2c_rm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    line_pair_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // SDA edges while SCL stays high frame a transfer
    assign scl_rise  =  scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s &  prev_q.scl;
    assign start_det =  scl_s &  prev_q.scl &  prev_q.sda & ~sda_s;
    assign stop_det  =  scl_s &  prev_q.scl & ~prev_q.sda &  sda_s;

endmodule

// File: rtl/i2c_rm_engine.sv
module i2c_rm_engine
    import i2c_rm_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         NUM_REGS = 19,
    parameter int         FIRST_RW = 7,
    parameter logic [7:0] RST_CMD  = 8'hBF,
    parameter logic [7:0] GC_CODE  = 8'h06
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rdata,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic [7:0]       wdata,
    output logic             we,
    output logic             re,
    output logic             rst_pulse
);

    localparam logic [PTR_W-1:0] RW_LO = PTR_W'(FIRST_RW);
    localparam logic [PTR_W-1:0] RW_HI = PTR_W'(NUM_REGS);
    localparam logic [3:0]       BYTE_BITS = 4'd8;

    eng_regs_t q, n;

    always_comb begin
        n     = q;
        n.we  = 1'b0;
        n.re  = 1'b0;
        n.rst = 1'b0;
        n.inc = 1'b0;
        // pointer step deferred by one cycle so the strobe sees the old pointer
        if (q.inc) n.ptr = q.ptr + 1'b1;

        if (stop_det) begin
            n.state  = ST_IDLE;
            n.ptr    = '0;
            n.sda_oe = 1'b0;
        end else if (start_det) begin
            n.state  = ST_RX;
            n.phase  = PH_ADDR;
            n.cnt    = '0;
            n.sda_oe = 1'b0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    n.sda_oe = 1'b0;
                end
                ST_RX: begin
                    if (scl_rise && q.cnt < BYTE_BITS) begin
                        n.shift = {q.shift[6:0], sda_s};
                        n.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BYTE_BITS) begin
                        n.state  = ST_ACK;
                        n.sda_oe = 1'b1;
                        n.after  = NX_RX;
                        unique case (q.phase)
                            PH_ADDR: begin
                                if (q.shift[7:1] == DEV_ADDR) begin
                                    n.phase = PH_PTR;
                                    n.after = q.shift[0] ? NX_READ : NX_RX;
                                end else if (q.shift == 8'h00) begin
                                    n.phase = PH_GC;
                                end else begin
                                    n.state  = ST_IDLE;
                                    n.sda_oe = 1'b0;
                                end
                            end
                            PH_PTR: begin
                                n.phase = PH_DATA;
                                if (q.shift == RST_CMD) begin
                                    n.rst = 1'b1;
                                    n.ptr = '0;
                                end else begin
                                    n.ptr = q.shift;
                                end
                            end
                            PH_DATA: begin
                                n.we    = (q.ptr >= RW_LO) && (q.ptr < RW_HI);
                                n.wdata = q.shift;
                                n.inc   = 1'b1;
                            end
                            PH_GC: begin
                                if (q.shift == GC_CODE) begin
                                    n.rst   = 1'b1;
                                    n.after = NX_IDLE;
                                end else begin
                                    n.state  = ST_IDLE;
                                    n.sda_oe = 1'b0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.sda_oe = 1'b0;
                        n.cnt    = '0;
                        unique case (q.after)
                            NX_READ: n.state = ST_RD_LOAD;
                            NX_IDLE: n.state = ST_IDLE;
                            default: n.state = ST_RX;
                        endcase
                    end
                end
                ST_RD_LOAD: begin
                    n.shift  = rdata;
                    n.re     = 1'b1;
                    n.sda_oe = ~rdata[7];
                    n.cnt    = '0;
                    n.state  = ST_RD_BIT;
                end
                ST_RD_BIT: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            n.sda_oe = 1'b0;
                            n.mack   = 1'b0;
                            n.state  = ST_RD_ACK;
                        end else begin
                            n.shift  = {q.shift[6:0], 1'b0};
                            n.sda_oe = ~q.shift[6];
                            n.cnt    = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) n.mack = ~sda_s;
                    if (scl_fall) begin
                        if (q.mack) begin
                            n.ptr   = q.ptr + 1'b1;
                            n.state = ST_RD_LOAD;
                        end else begin
                            n.state = ST_IDLE;
                        end
                    end
                end
                default: n.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_ADDR, after: NX_RX, default: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe    = q.sda_oe;
    assign ptr       = q.ptr;
    assign wdata     = q.wdata;
    assign we        = q.we;
    assign re        = q.re;
    assign rst_pulse = q.rst;

    // R4: any STOP leaves the pointer at zero
    a_r4_stop_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.ptr == '0));

    // R3: START or repeated START restarts address reception
    a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (q.state == ST_RX && q.phase == PH_ADDR && q.cnt == '0));

    // R2: each write strobe is one cycle and is followed by one pointer step
    a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);
    a_r2_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (q.we && !stop_det) |=> (q.ptr == PTR_W'($past(q.ptr) + 1'b1)));

    // R1: an idle target never holds SDA low
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !q.sda_oe);

    // R7: register reset is a single-cycle pulse
    a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst |=> !q.rst);

endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
    import i2c_rm_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         NUM_REGS    = 19,
    parameter int         FIRST_RW    = 7,
    parameter logic [7:0] RST_CMD     = 8'hBF,
    parameter logic [7:0] GC_CODE     = 8'h06
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [PTR_W-1:0] reg_addr,
    input  logic [7:0]       reg_rdata,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    output logic             reg_re,
    output logic             regs_reset
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines, sync_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {scl_i, sda_i};

    i2c_rm_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .dout  (sync_lines)
    );

    i2c_rm_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (sync_lines[1]),
        .sda_s     (sync_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rm_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .FIRST_RW (FIRST_RW),
        .RST_CMD  (RST_CMD),
        .GC_CODE  (GC_CODE)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sync_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (reg_rdata),
        .sda_oe    (sda_oe),
        .ptr       (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .re        (reg_re),
        .rst_pulse (regs_reset)
    );

    // R6: write strobes only ever reach the writable window
    a_r6_we_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr >= PTR_W'(FIRST_RW) && reg_addr < PTR_W'(NUM_REGS)));

    // R9: a strobe and a register reset never coincide
    a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_we, reg_re, regs_reset}) <= 1);

endmodule

// File: tb/sim_i2c_regmap_target.sv
module sim_i2c_regmap_target;

    localparam int Q  = 8;
    localparam int WD = 150000;
    // {pointer, data written, value expected on read-back}
    localparam logic [23:0] VEC [0:7] = '{
        24'h07_5A_5A, 24'h08_C3_C3, 24'h12_FF_FF, 24'h0A_3C_3C,
        24'h00_55_A0, 24'h06_77_A6, 24'h13_12_EE, 24'h11_81_81
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, reg_we, reg_re, regs_reset;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    int checks = 0, failures = 0, we_cnt = 0, rst_cnt = 0;
    logic [7:0] rf [0:18];

    assign sda_line = sda_m & ~sda_oe;

    i2c_regmap_target u0 (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
        .sda_oe (sda_oe), .reg_addr (reg_addr), .reg_rdata (reg_rdata),
        .reg_wdata (reg_wdata), .reg_we (reg_we), .reg_re (reg_re),
        .regs_reset (regs_reset)
    );

    function automatic logic [7:0] dflt(int i);
        return (i < 7) ? 8'(8'hA0 + i) : 8'(8'h10 + i);
    endfunction

    // register file model beside the target
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 19; i++) rf[i] <= dflt(i);
        end else if (regs_reset) begin
            for (int i = 0; i < 19; i++) rf[i] <= dflt(i);
            rst_cnt <= rst_cnt + 1;
        end else if (reg_we) begin
            if (reg_addr < 8'd19) rf[reg_addr[4:0]] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end
    assign reg_rdata = (reg_addr < 8'd19) ? rf[reg_addr[4:0]] : 8'hEE;

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic rd1(input logic [7:0] p, output logic [7:0] b);
        logic a;
        bus_start(); send(8'h90, a); send(p, a);
        bus_start(); send(8'h91, a); recv(1'b0, b); bus_stop();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a0, a1, a2, a3;
        logic [7:0] b0, b1, b2;
        int w0, r0;
        tick(4); rst_n = 1'b1; tick(3);
        // R9 reset state
        chk("R9 sda_oe", sda_oe, 0);
        chk("R9 reg_we", reg_we, 0);
        chk("R9 reg_re", reg_re, 0);
        chk("R9 regs_reset", regs_reset, 0);
        chk("R9 reg_addr", reg_addr, 0);

        // table: single write then read-back via repeated START
        for (int v = 0; v < 8; v++) begin
            logic [7:0] p, d, e;
            logic wr;
            {p, d, e} = VEC[v];
            wr = (p >= 8'h07) && (p <= 8'h12);
            w0 = we_cnt;
            bus_start(); send(8'h90, a0); send(p, a1); send(d, a2); bus_stop(); tick(4);
            chk("R1 write address ack", a0, 1);
            chk(wr ? "R2 data ack" : "R6 data ack", a2, 1);
            chk(wr ? "R2 one strobe" : "R6 no strobe", we_cnt - w0, wr ? 1 : 0);
            bus_start(); send(8'h90, a0); send(p, a1);
            bus_start(); send(8'h91, a3); recv(1'b0, b0); bus_stop();
            chk("R1 read address ack", a3, 1);
            chk(wr ? "R3 read-back" : "R6 unchanged", b0, e);
        end

        // R1 foreign address: no ack, following bytes ignored
        w0 = we_cnt;
        bus_start(); send(8'hA2, a0); send(8'h07, a1); send(8'h99, a2); bus_stop(); tick(4);
        chk("R1 foreign nack", a0, 0);
        chk("R1 foreign ignored", we_cnt - w0, 0);

        // R2 burst write, R5 burst read with host acks
        bus_start(); send(8'h90, a0); send(8'h0D, a0);
        send(8'h11, a0); send(8'h22, a0); send(8'h33, a0); bus_stop();
        bus_start(); send(8'h90, a0); send(8'h0D, a0);
        bus_start(); send(8'h91, a0);
        recv(1'b1, b0); recv(1'b1, b1); recv(1'b0, b2); bus_stop();
        chk("R5 burst byte0", b0, 8'h11);
        chk("R5 burst byte1", b1, 8'h22);
        chk("R2 burst byte2", b2, 8'h33);

        // R4 STOP clears pointer: bare read returns entry 0
        bus_start(); send(8'h90, a0); send(8'h0E, a0); bus_stop();
        bus_start(); send(8'h91, a0); recv(1'b0, b0); bus_stop();
        chk("R4 bare read", b0, 8'hA0);

        // R5 NACK leaves pointer: second repeated-START read same entry
        bus_start(); send(8'h90, a0); send(8'h0E, a0);
        bus_start(); send(8'h91, a0); recv(1'b0, b0);
        bus_start(); send(8'h91, a0); recv(1'b0, b1); bus_stop();
        chk("R5 first read", b0, 8'h22);
        chk("R5 pointer kept after nack", b1, 8'h22);

        // R7 general call with wrong command
        r0 = rst_cnt;
        bus_start(); send(8'h00, a0); send(8'h07, a1); bus_stop(); tick(4);
        chk("R7 gc address ack", a0, 1);
        chk("R7 wrong command nack", a1, 0);
        chk("R7 no reset pulse", rst_cnt - r0, 0);
        rd1(8'h08, b0);
        chk("R7 register kept", b0, 8'hC3);

        // R7 general call reset
        bus_start(); send(8'h00, a0); send(8'h06, a1); bus_stop(); tick(4);
        chk("R7 reset command ack", a1, 1);
        chk("R7 reset pulse", rst_cnt - r0, 1);
        rd1(8'h08, b0);
        chk("R7 default restored", b0, 8'h18);

        // R8 reserved pointer reset
        bus_start(); send(8'h90, a0); send(8'h08, a0); send(8'h99, a0); bus_stop();
        r0 = rst_cnt;
        bus_start(); send(8'h90, a0); send(8'hBF, a1); bus_stop(); tick(4);
        chk("R8 command ack", a1, 1);
        chk("R8 reset pulse", rst_cnt - r0, 1);
        rd1(8'h08, b0);
        chk("R8 default restored", b0, 8'h18);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule